// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the target side of a slow, three-wire debug link, clocked by the processor clock. An external debug host supplies a serial clock and a serial data line. The block returns one serial output, which carries two kinds of traffic. It sends register contents to the host, and it gives the host active-low handshake pulses. The serial clock must run at no more than one eighth of the processor clock rate. The block oversamples both inputs through a two-flop synchronizer and finds the serial clock edges in the processor clock domain. Each pin change reaches the controller three processor clocks after it happens.

When the debug request input is high, the port leaves its idle state and pulses the output low to show that it is waiting for a command. The host then shifts in an 8-bit command, most significant bit first.
- A read command is acknowledged with a pulse. The host then clocks out the 16-bit contents of the addressed register, most significant bit first.
- A write command is acknowledged with a pulse. The host then shifts in 16 data bits, and a second pulse confirms the register update.

If the serial clock moves while a pulse is being driven, that edge is discarded and a sticky error flag is raised.

The controller states are `ST_IDLE`, `ST_ACK`, `ST_CMD`, `ST_RD` and `ST_WR`. The transitions are:
- idle-to-ack, on the debug request.
- ack-to-return-state, after two clocks. The return state is `ST_CMD`, `ST_RD` or `ST_WR`.
- cmd-to-ack, on the eighth command bit.
- cmd-to-idle, when the request is dropped between commands.
- rd-to-cmd, on the falling edge after the sixteenth data bit.
- wr-to-ack, on the sixteenth data bit.

Top module: `dbg_serial_port`

## Requirements
- R1: During and after reset, `ser_dout` is 1 and `proto_err` is 0. All sixteen registers read back as 0.
- R2: In idle, a high `dbg_req` starts exactly one low pulse on `ser_dout`. The pulse lasts exactly 2 processor clocks, and the port then waits for a command.
- R3: A command is 8 bits, taken on falling serial clock edges, most significant bit first. Bit 7 = 1 means read and bit 7 = 0 means write. Bits 3:0 address one of sixteen 16-bit registers. Bits 6:4 have no effect.
- R4: After the eighth bit of a read command, `ser_dout` gives one 2-clock low pulse before any data bit is driven.
- R5: During a read, each rising serial clock edge puts the next bit of the addressed register on `ser_dout`, most significant bit first, 16 bits in all. The falling edge after the sixteenth bit returns the port to command wait, with `ser_dout` high.
- R6: After the eighth bit of a write command, `ser_dout` gives one 2-clock low pulse to ask for the data.
- R7: The 16 write data bits are taken on falling edges, most significant bit first, and stored in the addressed register. A second 2-clock low pulse follows the store.
- R8: A serial clock edge seen while a pulse is being driven is ignored and sets `proto_err`. `proto_err` then stays 1 until reset.
- R9: Serial clock activity in idle has no effect. Dropping `dbg_req` while no command bit is pending returns the port to idle with `ser_dout` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Debug mode request, level sensitive |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_din | input | 1 | Serial data from the host, asynchronous |
| ser_dout | output | 1 | Serial data and active-low handshake pulses to the host |
| proto_err | output | 1 | Sticky flag: a serial clock edge arrived during a pulse |

## Verification
A pin change is acted on at the third rising processor clock after it is driven.
- A handshake pulse therefore goes low at that edge and lasts two clocks.
- A read data bit appears three clocks after its rising serial edge.

The bench keeps its own copy of the last three sampled pin values and steps a behavioural protocol model at every clock edge. It compares `ser_dout` and `proto_err` with the model at the opposite clock edge, so every pulse and data bit is checked in the exact cycle it is due. The host tasks wait five clocks per half period before sampling, well past the three-clock latency.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    localparam int DBGP_DATA_W     = 16;
    localparam int DBGP_ADDR_W     = 4;
    localparam int DBGP_CMD_W      = 8;
    localparam int DBGP_SYNC_STG   = 2;
    localparam int DBGP_ACK_CYCLES = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACK  = 3'd1,
        ST_CMD  = 3'd2,
        ST_RD   = 3'd3,
        ST_WR   = 3'd4
    } dbgp_state_e;

endpackage

// File: rtl/dbgp_edge_sync.sv
module dbgp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic sdi_pin,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi
);

    logic [STAGES-1:0] ck_pipe;
    logic [STAGES-1:0] dt_pipe;
    logic              ck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_pipe[0] <= sck_pin;
            dt_pipe[0] <= sdi_pin;
            for (int i = 1; i < STAGES; i++) begin
                ck_pipe[i] <= ck_pipe[i-1];
                dt_pipe[i] <= dt_pipe[i-1];
            end
            ck_prev <= ck_pipe[STAGES-1];
        end
    end

    assign sck_rise = ck_pipe[STAGES-1] & ~ck_prev;
    assign sck_fall = ~ck_pipe[STAGES-1] & ck_prev;
    assign sdi      = dt_pipe[STAGES-1];

endmodule

// File: rtl/dbgp_regfile.sv
module dbgp_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_addr];

endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
    import dbgp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 4,
    parameter int CMD_W      = 8,
    parameter int ACK_CYCLES = 2,
    parameter int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_req,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ser_dout,
    output logic              proto_err,
    output logic              in_ack,
    output logic              in_idle,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam int ACK_W = $clog2(ACK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_DONE = CNT_W'(DATA_W);
    localparam logic [ACK_W-1:0] ACK_LAST  = ACK_W'(ACK_CYCLES - 1);

    dbgp_state_e       st_q, st_d;
    dbgp_state_e       ret_q, ret_d;
    logic [ACK_W-1:0]  ack_cnt;
    logic [CMD_W-2:0]  cmd_q;
    logic [CMD_W-1:0]  cmd_next;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt_q;
    logic              rbit_q;
    logic              rvalid_q;
    logic              err_q;
    logic              ack_last;
    logic              cmd_last;
    logic              data_last;

    assign cmd_next  = {cmd_q, sdi};
    assign ack_last  = (ack_cnt == ACK_LAST);
    assign cmd_last  = (cnt_q == CMD_LAST);
    assign data_last = (cnt_q == DATA_LAST);

    // next-state logic
    always_comb begin
        st_d  = st_q;
        ret_d = ret_q;
        unique case (st_q)
            ST_IDLE: begin
                if (dbg_req) begin
                    st_d  = ST_ACK;
                    ret_d = ST_CMD;
                end
            end
            ST_ACK: begin
                if (ack_last) st_d = ret_q;
            end
            ST_CMD: begin
                if (sck_fall && cmd_last) begin
                    st_d  = ST_ACK;
                    ret_d = cmd_next[CMD_W-1] ? ST_RD : ST_WR;
                end else if (!sck_fall && cnt_q == '0 && !dbg_req) begin
                    st_d = ST_IDLE;
                end
            end
            ST_RD: begin
                if (sck_fall && cnt_q == DATA_DONE) st_d = ST_CMD;
            end
            ST_WR: begin
                if (sck_fall && data_last) begin
                    st_d  = ST_ACK;
                    ret_d = ST_CMD;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ret_q <= ST_CMD;
        end else begin
            st_q  <= st_d;
            ret_q <= ret_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_cnt  <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            shreg    <= '0;
            cnt_q    <= '0;
            rbit_q   <= 1'b1;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            ack_cnt <= (st_q == ST_ACK) ? ack_cnt + ACK_W'(1) : '0;
            if (st_q == ST_ACK && (sck_rise || sck_fall)) err_q <= 1'b1;
            unique case (st_q)
                ST_CMD: begin
                    if (sck_fall) begin
                        cmd_q <= cmd_next[CMD_W-2:0];
                        if (cmd_last) begin
                            cnt_q  <= '0;
                            addr_q <= cmd_next[ADDR_W-1:0];
                            shreg  <= rd_data;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_RD: begin
                    if (sck_rise && cnt_q < DATA_DONE) begin
                        rbit_q   <= shreg[DATA_W-1];
                        shreg    <= {shreg[DATA_W-2:0], 1'b0};
                        rvalid_q <= 1'b1;
                        cnt_q    <= cnt_q + CNT_W'(1);
                    end
                    if (sck_fall && cnt_q == DATA_DONE) begin
                        cnt_q    <= '0;
                        rvalid_q <= 1'b0;
                    end
                end
                ST_WR: begin
                    if (sck_fall) begin
                        shreg <= {shreg[DATA_W-2:0], sdi};
                        cnt_q <= data_last ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign rd_addr = cmd_next[ADDR_W-1:0];
    assign wr_en   = (st_q == ST_WR) && sck_fall && data_last;
    assign wr_addr = addr_q;
    assign wr_data = {shreg[DATA_W-2:0], sdi};

    // outputs
    always_comb begin
        unique case (st_q)
            ST_ACK:  ser_dout = 1'b0;
            ST_RD:   ser_dout = rvalid_q ? rbit_q : 1'b1;
            default: ser_dout = 1'b1;
        endcase
        proto_err = err_q;
        in_ack    = (st_q == ST_ACK);
        in_idle   = (st_q == ST_IDLE);
        bit_cnt   = cnt_q;
    end

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbgp_pkg::*;
#(
    parameter int DATA_W     = DBGP_DATA_W,
    parameter int ADDR_W     = DBGP_ADDR_W,
    parameter int CMD_W      = DBGP_CMD_W,
    parameter int SYNC_STG   = DBGP_SYNC_STG,
    parameter int ACK_CYCLES = DBGP_ACK_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_req,
    input  logic ser_clk,
    input  logic ser_din,
    output logic ser_dout,
    output logic proto_err
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              sck_rise;
    logic              sck_fall;
    logic              sdi;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              in_ack;
    logic              in_idle;
    logic [CNT_W-1:0]  bit_cnt;

    dbgp_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (ser_clk),
        .sdi_pin  (ser_din),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi      (sdi)
    );

    dbgp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dbgp_ctrl #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CMD_W      (CMD_W),
        .ACK_CYCLES (ACK_CYCLES),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_req   (dbg_req),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi       (sdi),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ser_dout  (ser_dout),
        .proto_err (proto_err),
        .in_ack    (in_ack),
        .in_idle   (in_idle),
        .bit_cnt   (bit_cnt)
    );

endmodule

// File: rtl/dbgp_checker.sv
module dbgp_checker #(
    parameter int DATA_W     = 16,
    parameter int ACK_CYCLES = 2,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_dout,
    input logic             proto_err,
    input logic             in_ack,
    input logic             in_idle,
    input logic [CNT_W-1:0] bit_cnt
);

    int unsigned ack_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_run <= 0;
        else        ack_run <= in_ack ? ack_run + 1 : 0;
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> ser_dout);

    p_ack_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack |-> !ser_dout);

    // R4 R6 R7: every pulse has exactly the configured length
    p_ack_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_run != 0 && !in_ack) |-> ack_run == ACK_CYCLES);

    p_ack_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_run <= ACK_CYCLES);

    p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(DATA_W));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(in_ack));

endmodule

bind dbg_serial_port dbgp_checker #(
    .DATA_W     (DATA_W),
    .ACK_CYCLES (ACK_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_dout  (ser_dout),
    .proto_err (proto_err),
    .in_ack    (in_ack),
    .in_idle   (in_idle),
    .bit_cnt   (bit_cnt)
);

// File: tb/dbg_serial_port_test.sv
`timescale 1ns/1ps
module dbg_serial_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_req = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic proto_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_serial_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_req   (dbg_req),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout),
        .proto_err (proto_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural protocol model ----------------
    // states: 0 idle, 1 pulse, 2 command, 3 read out, 4 write in
    int c1, c2, c3, d1, d2;
    int m_st, m_ret, m_ackc, m_cnt, m_cmd, m_addr, m_sh, m_rbit, m_rv, m_err;
    int mem [16];
    int exp_dout = 1;
    bit model_on = 1'b0;

    always @(posedge clk) begin
        int rise, fall, sd, nst;
        if (!rst_n) begin
            c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0;
            m_st = 0; m_ret = 2; m_ackc = 0; m_cnt = 0; m_cmd = 0;
            m_addr = 0; m_sh = 0; m_rbit = 1; m_rv = 0; m_err = 0;
            for (int i = 0; i < 16; i++) mem[i] = 0;
        end else begin
            rise = (c2 == 1 && c3 == 0);
            fall = (c2 == 0 && c3 == 1);
            sd = d2;
            nst = m_st;
            case (m_st)
                0: if (dbg_req) begin nst = 1; m_ret = 2; end
                1: begin
                    if (rise || fall) m_err = 1;
                    if (m_ackc == 1) nst = m_ret;
                end
                2: begin
                    if (fall) begin
                        m_cmd = ((m_cmd << 1) | sd) & 255;
                        if (m_cnt == 7) begin
                            m_cnt = 0;
                            m_addr = m_cmd & 15;
                            m_sh = mem[m_addr];
                            nst = 1;
                            m_ret = (m_cmd >= 128) ? 3 : 4;
                        end else m_cnt++;
                    end else if (m_cnt == 0 && !dbg_req) nst = 0;
                end
                3: begin
                    if (rise && m_cnt < 16) begin
                        m_rbit = (m_sh >> 15) & 1;
                        m_sh = (m_sh << 1) & 65535;
                        m_rv = 1;
                        m_cnt++;
                    end
                    if (fall && m_cnt == 16) begin
                        m_cnt = 0; m_rv = 0; nst = 2;
                    end
                end
                4: begin
                    if (fall) begin
                        m_sh = ((m_sh << 1) | sd) & 65535;
                        if (m_cnt == 15) begin
                            mem[m_addr] = m_sh;
                            m_cnt = 0; nst = 1; m_ret = 2;
                        end else m_cnt++;
                    end
                end
                default: nst = 0;
            endcase
            m_ackc = (m_st == 1) ? m_ackc + 1 : 0;
            m_st = nst;
            c3 = c2; c2 = c1; c1 = int'(ser_clk);
            d2 = d1; d1 = int'(ser_din);
        end
        exp_dout = (m_st == 1) ? 0 : ((m_st == 3 && m_rv == 1) ? m_rbit : 1);
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            check(ser_dout == exp_dout[0], "R2 R4 R5 R6 R7", "cycle model ser_dout",
                  int'(ser_dout), exp_dout);
            check(proto_err == m_err[0], "R8", "cycle model proto_err",
                  int'(proto_err), m_err);
        end
    end

    // pulse monitor (ignores the read data window)
    int ack_count = 0;
    int low_run = 0;
    int last_w = 0;
    bit reading = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            low_run = 0;
        end else if (ser_dout == 1'b0 && !reading) begin
            low_run++;
        end else if (low_run > 0) begin
            ack_count++;
            last_w = low_run;
            low_run = 0;
        end
    end

    // ---------------- host tasks ----------------
    task automatic sbit(input logic b);
        @(negedge clk);
        ser_din = b;
        ser_clk = 1'b1;
        repeat (5) @(negedge clk);
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic wait_ack(input int want, input string tag);
        int n = 0;
        while (ack_count < want && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(ack_count == want, tag, "pulse count", ack_count, want);
        check(last_w == 2, tag, "pulse width", last_w, 2);
    endtask

    int acks_exp = 0;

    task automatic do_write(input logic [7:0] cmd, input logic [15:0] val);
        send_byte(cmd);
        acks_exp++;
        wait_ack(acks_exp, "R6");
        for (int i = 15; i >= 0; i--) sbit(val[i]);
        acks_exp++;
        wait_ack(acks_exp, "R7");
    endtask

    task automatic do_read(input logic [7:0] cmd, output logic [15:0] val);
        send_byte(cmd);
        acks_exp++;
        wait_ack(acks_exp, "R4");
        reading = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            ser_clk = 1'b1;
            repeat (5) @(negedge clk);
            val[i] = ser_dout;
            ser_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
        reading = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rv;
        repeat (5) @(negedge clk);
        model_on = 1'b1;
        check(ser_dout == 1'b1, "R1", "dout in reset", int'(ser_dout), 1);
        check(proto_err == 1'b0, "R1", "err in reset", int'(proto_err), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ser_dout == 1'b1, "R1", "dout after reset", int'(ser_dout), 1);

        // R9: idle clock activity ignored
        for (int i = 0; i < 4; i++) sbit(i[0]);
        repeat (10) @(negedge clk);
        check(ser_dout == 1'b1, "R9", "dout idle after toggles", int'(ser_dout), 1);
        check(ack_count == 0, "R9", "no pulse in idle", ack_count, 0);

        // R2: debug entry
        dbg_req = 1'b1;
        acks_exp++;
        wait_ack(acks_exp, "R2");

        // R1: reset register content
        do_read(8'h85, rv);
        check(rv == 16'h0000, "R1", "reg5 reset value", int'(rv), 0);

        // R7 writes
        do_write(8'h03, 16'hA5C3);
        do_write(8'h0C, 16'h0001);
        do_write(8'h00, 16'hFFFF);

        do_read(8'h83, rv);
        check(rv == 16'hA5C3, "R5", "read reg3", int'(rv), 32'hA5C3);
        do_read(8'h8C, rv);
        check(rv == 16'h0001, "R5", "read reg12", int'(rv), 1);
        do_read(8'h80, rv);
        check(rv == 16'hFFFF, "R5", "read reg0", int'(rv), 32'hFFFF);

        // R3: bits 6:4 have no effect
        do_read(8'hF3, rv);
        check(rv == 16'hA5C3, "R3", "read with bits 6:4 set", int'(rv), 32'hA5C3);
        do_write(8'h7C, 16'h8000);
        do_read(8'h8C, rv);
        check(rv == 16'h8000, "R3", "write with bits 6:4 set", int'(rv), 32'h8000);
        do_read(8'h83, rv);
        check(rv == 16'hA5C3, "R3", "other reg untouched", int'(rv), 32'hA5C3);

        // R9: leave debug, re-enter
        @(negedge clk);
        dbg_req = 1'b0;
        repeat (10) @(negedge clk);
        check(ser_dout == 1'b1, "R9", "dout after leaving debug", int'(ser_dout), 1);
        check(ack_count == acks_exp, "R9", "no pulse on exit", ack_count, acks_exp);
        dbg_req = 1'b1;
        acks_exp++;
        wait_ack(acks_exp, "R2");

        // R8: serial clock edge during a pulse
        for (int i = 7; i >= 1; i--) sbit(1'b0);
        @(negedge clk);
        ser_din = 1'b1;
        ser_clk = 1'b1;
        repeat (5) @(negedge clk);
        ser_clk = 1'b0;
        @(negedge clk);
        ser_clk = 1'b1;
        repeat (10) @(negedge clk);
        check(proto_err == 1'b1, "R8", "err after edge in pulse", int'(proto_err), 1);
        check(last_w == 2, "R8", "pulse length kept", last_w, 2);
        ser_clk = 1'b0;
        repeat (20) @(negedge clk);
        check(proto_err == 1'b1, "R8", "err sticky", int'(proto_err), 1);

        // reset clears the flag
        rst_n = 1'b0;
        dbg_req = 1'b0;
        repeat (3) @(negedge clk);
        check(proto_err == 1'b0, "R1", "err cleared by reset", int'(proto_err), 0);
        check(ser_dout == 1'b1, "R1", "dout high in reset", int'(ser_dout), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule